// File: doc/BRIEF.md
# Serial Transceiver Reset Manager

This block sits in the fabric next to a two-lane serial transceiver tile. It watches the tile's status and error flags and drives the tile's reset inputs. Each fault class is mapped to the reset that disturbs the smallest part of the tile. A reference-clock event resets the whole tile so that the shared PLL can relock. A lane buffer error resets only that lane's buffer or PCS. A PRBS clear request touches only that lane's error counter. Loss of lock on the fabric clock source holds the PCS resets asserted until lock returns.

Before channel bonding, the block runs an ordered sequence. It resets the receive CDR of every lane, waits for all CDRs to report lock, and then resets the receive elastic buffers. If lock does not appear within a programmable number of cycles, the CDR reset is issued again and a sticky timeout flag is raised.

Every status input passes through a two-flop synchronizer. Event inputs are then edge-detected, so a flag that stays high yields a single reset pulse. Each pulse lasts a programmable number of cycles. While the tile reset is active, all per-lane requests and bonding requests are dropped.

Top module: `xrm_reset_mgr`

## Requirements
- R1: A rising edge on `refclk_evt` asserts `tile_rst` for exactly TILE_HOLD cycles (default 16).
- R2: While `usr_lock` is low, both lanes of `tx_pcs_rst` and `rx_pcs_rst` stay asserted. This includes the time from reset until lock has passed the synchronizer. They release two clock edges after `usr_lock` returns high.
- R3: A rising edge on `tx_buf_err[i]` asserts only `tx_pcs_rst[i]`, for HOLD cycles (default 8). The pulse is first visible in the third clock cycle after the input is presented.
- R4: A rising edge on `rx_buf_err[i]` asserts only `rxbuf_rst[i]`, for HOLD cycles.
- R5: A rising edge on `bond_req` asserts `cdr_rst` on all lanes for HOLD cycles. Then, once every `cdr_lock` bit has been seen high, it asserts `rxbuf_rst` on all lanes for HOLD cycles. No buffer reset is issued from this sequence while any lane lacks lock.
- R6: A rising edge on `prbs_clr[i]` asserts only `prbs_rst[i]`, for HOLD cycles.
- R7: A rising edge on `os_err[i]` asserts only `rx_pcs_rst[i]`, for HOLD cycles.
- R8: An event input held high produces one reset pulse, not a repeating one.
- R9: While `tile_rst` is high, new edges on the per-lane event inputs and on `bond_req` produce no reset. The edge is consumed, not deferred.
- R10: If CDR lock is not seen within TMO cycles (default 64) after the CDR reset, the CDR reset is repeated and `bond_tmo` goes high. `bond_tmo` stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refclk_evt | input | 1 | Reference clock changed or became available |
| usr_lock | input | 1 | Lock flag of the user parallel clock source |
| tx_buf_err | input | NL | Per-lane transmit buffer error |
| rx_buf_err | input | NL | Per-lane receive elastic buffer error |
| os_err | input | NL | Per-lane oversampler error |
| cdr_lock | input | NL | Per-lane receive CDR lock |
| bond_req | input | 1 | Request to prepare lanes for channel bonding |
| prbs_clr | input | NL | Per-lane PRBS error counter clear request |
| tile_rst | output | 1 | Whole-tile reset |
| tx_pcs_rst | output | NL | Per-lane transmit PCS reset |
| rx_pcs_rst | output | NL | Per-lane receive PCS reset |
| cdr_rst | output | NL | Per-lane receive CDR reset |
| rxbuf_rst | output | NL | Per-lane receive elastic buffer reset |
| prbs_rst | output | NL | Per-lane PRBS error counter reset |
| bond_tmo | output | 1 | Sticky CDR lock timeout flag |

## Verification
The bench counts how many cycles each reset output is high over a window after every stimulus. If a fault leaked into a neighbouring lane or into the wrong reset class, a non-zero count would appear on an output that should stay quiet. Holding an error flag high tests R8: if the design were level-triggered instead of edge-triggered, the pulse count would grow well past HOLD.

A buffer error raised during a tile reset must leave no trace afterwards. A design that queued the edge would pulse the transmit PCS reset once the tile reset ends. With CDR lock withheld, the bonding sequence must retry its CDR reset and set the timeout flag without ever resetting the buffer. Once lock is supplied, exactly one buffer reset must follow.

// File: rtl/xrm_pkg.sv
package xrm_pkg;

   typedef enum logic [1:0] {
      BS_IDLE = 2'd0,
      BS_CDR  = 2'd1,
      BS_WAIT = 2'd2,
      BS_BUF  = 2'd3
   } bond_st_e;

   function automatic int cnt_width(input int maxval);
      int w;
      w = $clog2(maxval + 1);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/xrm_sync.sv
module xrm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xrm_sync: STAGES must be 2 or more");
   end
   if (W < 1) begin : g_bad_width
      $error("xrm_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/xrm_stretch.sv
module xrm_stretch #(
   parameter int W    = 1,
   parameter int HOLD = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] trig,
   output logic [W-1:0] pulse
);
   import xrm_pkg::*;

   localparam int CW = cnt_width(HOLD);

   if (HOLD < 2) begin : g_bad_hold
      $error("xrm_stretch: HOLD must be 2 or more");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt <= '0;
         else if (trig[i])        cnt <= CW'(HOLD);
         else if (cnt != '0)      cnt <= cnt - CW'(1);
      end
      assign pulse[i] = (cnt != '0);
   end

endmodule

// File: rtl/xrm_bond_seq.sv
module xrm_bond_seq #(
   parameter int NL   = 2,
   parameter int HOLD = 8,
   parameter int TMO  = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic          lock_all,
   output logic [NL-1:0] cdr_rst_o,
   output logic          buf_rst_o,
   output logic          tmo_o
);
   import xrm_pkg::*;

   localparam int MAXC = (HOLD > TMO) ? HOLD : TMO;
   localparam int CW   = cnt_width(MAXC);

   if (TMO < 2) begin : g_bad_tmo
      $error("xrm_bond_seq: TMO must be 2 or more");
   end

   bond_st_e      st;
   logic [CW-1:0] cnt;
   logic          tmo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= BS_IDLE;
         cnt   <= '0;
         tmo_q <= 1'b0;
      end else if (abort) begin
         st  <= BS_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            BS_IDLE: if (start) begin
               st  <= BS_CDR;
               cnt <= CW'(HOLD - 1);
            end
            BS_CDR: if (cnt == '0) begin
               st  <= BS_WAIT;
               cnt <= CW'(TMO - 1);
            end else begin
               cnt <= cnt - CW'(1);
            end
            BS_WAIT: if (lock_all) begin
               st  <= BS_BUF;
               cnt <= CW'(HOLD - 1);
            end else if (cnt == '0) begin
               st    <= BS_CDR;
               cnt   <= CW'(HOLD - 1);
               tmo_q <= 1'b1;
            end else begin
               cnt <= cnt - CW'(1);
            end
            BS_BUF: if (cnt == '0) begin
               st <= BS_IDLE;
            end else begin
               cnt <= cnt - CW'(1);
            end
            default: st <= BS_IDLE;
         endcase
      end
   end

   assign cdr_rst_o = {NL{st == BS_CDR}};
   assign buf_rst_o = (st == BS_BUF);
   assign tmo_o     = tmo_q;

endmodule

// File: rtl/xrm_reset_mgr.sv
module xrm_reset_mgr #(
   parameter int NL        = 2,
   parameter int HOLD      = 8,
   parameter int TILE_HOLD = 16,
   parameter int TMO       = 64,
   parameter int SYNC_ST   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          refclk_evt,
   input  logic          usr_lock,
   input  logic [NL-1:0] tx_buf_err,
   input  logic [NL-1:0] rx_buf_err,
   input  logic [NL-1:0] os_err,
   input  logic [NL-1:0] cdr_lock,
   input  logic          bond_req,
   input  logic [NL-1:0] prbs_clr,
   output logic          tile_rst,
   output logic [NL-1:0] tx_pcs_rst,
   output logic [NL-1:0] rx_pcs_rst,
   output logic [NL-1:0] cdr_rst,
   output logic [NL-1:0] rxbuf_rst,
   output logic [NL-1:0] prbs_rst,
   output logic          bond_tmo
);

   localparam int NEV  = 2 + 4 * NL;
   localparam int NLV  = 1 + NL;
   localparam int NLN  = 4 * NL;

   if (NL < 1) begin : g_bad_lanes
      $error("xrm_reset_mgr: NL must be positive");
   end

   // event inputs: bit 0 refclk, bit 1 bond, then tx, rx, os, prbs lanes
   logic [NEV-1:0] ev_raw, ev_s, ev_prev, ev_rise;
   logic [NLV-1:0] lv_raw, lv_s;

   assign ev_raw = {prbs_clr, os_err, rx_buf_err, tx_buf_err, bond_req, refclk_evt};
   assign lv_raw = {cdr_lock, usr_lock};

   xrm_sync #(.W(NEV), .STAGES(SYNC_ST)) u_sync_ev (
      .clk(clk), .rst_n(rst_n), .d(ev_raw), .q(ev_s));

   xrm_sync #(.W(NLV), .STAGES(SYNC_ST)) u_sync_lv (
      .clk(clk), .rst_n(rst_n), .d(lv_raw), .q(lv_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_prev <= '0;
      else        ev_prev <= ev_s;
   end
   assign ev_rise = ev_s & ~ev_prev;

   logic lock_s, lock_all;
   assign lock_s   = lv_s[0];
   assign lock_all = &lv_s[NLV-1:1];

   // whole-tile reset
   xrm_stretch #(.W(1), .HOLD(TILE_HOLD)) u_tile (
      .clk(clk), .rst_n(rst_n), .trig(ev_rise[0]), .pulse(tile_rst));

   // per-lane requests, dropped while the tile reset runs
   logic [NLN-1:0] lane_trig, lane_pulse;
   assign lane_trig = ev_rise[NEV-1:2] & {NLN{~tile_rst}};

   xrm_stretch #(.W(NLN), .HOLD(HOLD)) u_lane (
      .clk(clk), .rst_n(rst_n), .trig(lane_trig), .pulse(lane_pulse));

   logic [NL-1:0] tx_p, rxb_p, os_p, prbs_p;
   assign tx_p   = lane_pulse[0*NL +: NL];
   assign rxb_p  = lane_pulse[1*NL +: NL];
   assign os_p   = lane_pulse[2*NL +: NL];
   assign prbs_p = lane_pulse[3*NL +: NL];

   // pre-bonding sequence
   logic          seq_start, seq_buf;
   logic [NL-1:0] seq_cdr;
   assign seq_start = ev_rise[1] & ~tile_rst;

   xrm_bond_seq #(.NL(NL), .HOLD(HOLD), .TMO(TMO)) u_bond (
      .clk(clk), .rst_n(rst_n), .start(seq_start), .abort(tile_rst),
      .lock_all(lock_all), .cdr_rst_o(seq_cdr), .buf_rst_o(seq_buf),
      .tmo_o(bond_tmo));

   assign tx_pcs_rst = tx_p | {NL{~lock_s}};
   assign rx_pcs_rst = os_p | {NL{~lock_s}};
   assign cdr_rst    = seq_cdr;
   assign rxbuf_rst  = rxb_p | {NL{seq_buf}};
   assign prbs_rst   = prbs_p;

endmodule

// File: rtl/xrm_reset_mgr_chk.sv
module xrm_reset_mgr_chk #(
   parameter int NL = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          usr_lock,
   input logic          tile_rst,
   input logic [NL-1:0] tx_pcs_rst,
   input logic [NL-1:0] rx_pcs_rst,
   input logic [NL-1:0] prbs_rst,
   input logic          bond_tmo,
   input logic          seq_buf,
   input logic          lock_all
);

   // R1: tile reset never shorter than two cycles
   a_r1_tile_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tile_rst) |=> tile_rst);

   // R2: lock low long enough to cross the synchronizer holds all PCS resets
   a_r2_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!usr_lock && $past(!usr_lock) && $past(!usr_lock, 2))
         |-> (&tx_pcs_rst && &rx_pcs_rst));

   // R5: the bonding buffer reset begins only after lock was seen
   a_r5_buf_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_buf) |-> $past(lock_all));

   // R10: timeout flag is sticky
   a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bond_tmo |=> bond_tmo);

   for (genvar i = 0; i < NL; i++) begin : g_lane
      // R6: counter reset pulse lasts more than one cycle
      a_r6_prbs_min: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(prbs_rst[i]) |=> prbs_rst[i]);
      // R9: no new counter reset starts inside a running tile reset
      a_r9_no_start_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
         (tile_rst && $past(tile_rst)) |-> !$rose(prbs_rst[i]));
   end

endmodule

bind xrm_reset_mgr xrm_reset_mgr_chk #(.NL(NL)) u_chk (
   .clk(clk), .rst_n(rst_n), .usr_lock(usr_lock), .tile_rst(tile_rst),
   .tx_pcs_rst(tx_pcs_rst), .rx_pcs_rst(rx_pcs_rst), .prbs_rst(prbs_rst),
   .bond_tmo(bond_tmo), .seq_buf(seq_buf), .lock_all(lock_all));

// File: tb/sim_xrm_reset_mgr.sv
`timescale 1ns/1ps
module sim_xrm_reset_mgr;

   localparam int NL  = 2;
   localparam int WIN = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          refclk_evt = 1'b0, usr_lock = 1'b0, bond_req = 1'b0;
   logic [NL-1:0] tx_buf_err = '0, rx_buf_err = '0, os_err = '0;
   logic [NL-1:0] cdr_lock = '1, prbs_clr = '0;
   logic          tile_rst, bond_tmo;
   logic [NL-1:0] tx_pcs_rst, rx_pcs_rst, cdr_rst, rxbuf_rst, prbs_rst;

   always #2 clk = ~clk;

   xrm_reset_mgr u0 (
      .clk(clk), .rst_n(rst_n), .refclk_evt(refclk_evt), .usr_lock(usr_lock),
      .tx_buf_err(tx_buf_err), .rx_buf_err(rx_buf_err), .os_err(os_err),
      .cdr_lock(cdr_lock), .bond_req(bond_req), .prbs_clr(prbs_clr),
      .tile_rst(tile_rst), .tx_pcs_rst(tx_pcs_rst), .rx_pcs_rst(rx_pcs_rst),
      .cdr_rst(cdr_rst), .rxbuf_rst(rxbuf_rst), .prbs_rst(prbs_rst),
      .bond_tmo(bond_tmo));

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stim: 0 tx err, 1 rx buf err, 2 os err, 3 prbs clr, 4 refclk, 5 bond
   typedef struct packed {
      logic [2:0] stim;
      logic       lane;
      logic       hold;
      logic [4:0] tile, tx0, tx1, rx0, rx1, cd0, cd1, bf0, bf1, pb0, pb1;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{3'd0,1'b0,1'b0, 5'd0, 5'd8,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0}, // R3
      '{3'd0,1'b1,1'b1, 5'd0, 5'd0,5'd8, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0}, // R3 R8
      '{3'd1,1'b0,1'b0, 5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd8,5'd0, 5'd0,5'd0}, // R4
      '{3'd1,1'b1,1'b1, 5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd8, 5'd0,5'd0}, // R4 R8
      '{3'd2,1'b0,1'b0, 5'd0, 5'd0,5'd0, 5'd8,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0}, // R7
      '{3'd2,1'b1,1'b0, 5'd0, 5'd0,5'd0, 5'd0,5'd8, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0}, // R7
      '{3'd3,1'b1,1'b0, 5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd8}, // R6
      '{3'd3,1'b0,1'b1, 5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd8,5'd0}, // R6 R8
      '{3'd4,1'b0,1'b0, 5'd16,5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd0,5'd0}, // R1
      '{3'd5,1'b0,1'b0, 5'd0, 5'd0,5'd0, 5'd0,5'd0, 5'd8,5'd8, 5'd8,5'd8, 5'd0,5'd0}  // R5
   };

   task automatic drive(input logic [2:0] stim, input logic lane, input logic val);
      case (stim)
         3'd0: tx_buf_err[lane] = val;
         3'd1: rx_buf_err[lane] = val;
         3'd2: os_err[lane]     = val;
         3'd3: prbs_clr[lane]   = val;
         3'd4: refclk_evt       = val;
         default: bond_req      = val;
      endcase
   endtask

   int c_tile, c_tx0, c_tx1, c_rx0, c_rx1, c_cd0, c_cd1, c_bf0, c_bf1, c_pb0, c_pb1;

   task automatic clr_counts();
      c_tile = 0; c_tx0 = 0; c_tx1 = 0; c_rx0 = 0; c_rx1 = 0;
      c_cd0 = 0; c_cd1 = 0; c_bf0 = 0; c_bf1 = 0; c_pb0 = 0; c_pb1 = 0;
   endtask

   task automatic accum();
      c_tile += int'(tile_rst);
      c_tx0 += int'(tx_pcs_rst[0]); c_tx1 += int'(tx_pcs_rst[1]);
      c_rx0 += int'(rx_pcs_rst[0]); c_rx1 += int'(rx_pcs_rst[1]);
      c_cd0 += int'(cdr_rst[0]);    c_cd1 += int'(cdr_rst[1]);
      c_bf0 += int'(rxbuf_rst[0]);  c_bf1 += int'(rxbuf_rst[1]);
      c_pb0 += int'(prbs_rst[0]);   c_pb1 += int'(prbs_rst[1]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state (R2, R10)
      repeat (3) @(negedge clk);
      chk("R1 tile_rst in reset", int'(tile_rst), 0);
      chk("R2 tx_pcs_rst in reset", int'(tx_pcs_rst), 3);
      chk("R2 rx_pcs_rst in reset", int'(rx_pcs_rst), 3);
      chk("R5 cdr/buf in reset", int'({cdr_rst, rxbuf_rst}), 0);
      chk("R10 bond_tmo in reset", int'(bond_tmo), 0);
      rst_n = 1'b1;
      usr_lock = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 pcs released after lock", int'({tx_pcs_rst, rx_pcs_rst}), 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         clr_counts();
         drive(VEC[v].stim, VEC[v].lane, 1'b1);
         for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (c == 0 && !VEC[v].hold) drive(VEC[v].stim, VEC[v].lane, 1'b0);
            accum();
         end
         drive(VEC[v].stim, VEC[v].lane, 1'b0);
         chk($sformatf("R1 vec%0d tile", v), c_tile, int'(VEC[v].tile));
         chk($sformatf("R3 vec%0d tx0", v), c_tx0, int'(VEC[v].tx0));
         chk($sformatf("R3 vec%0d tx1", v), c_tx1, int'(VEC[v].tx1));
         chk($sformatf("R7 vec%0d rx0", v), c_rx0, int'(VEC[v].rx0));
         chk($sformatf("R7 vec%0d rx1", v), c_rx1, int'(VEC[v].rx1));
         chk($sformatf("R5 vec%0d cdr0", v), c_cd0, int'(VEC[v].cd0));
         chk($sformatf("R5 vec%0d cdr1", v), c_cd1, int'(VEC[v].cd1));
         chk($sformatf("R4 vec%0d buf0", v), c_bf0, int'(VEC[v].bf0));
         chk($sformatf("R4 vec%0d buf1", v), c_bf1, int'(VEC[v].bf1));
         chk($sformatf("R6 vec%0d prbs0", v), c_pb0, int'(VEC[v].pb0));
         chk($sformatf("R6 vec%0d prbs1", v), c_pb1, int'(VEC[v].pb1));
         repeat (20) @(negedge clk);
      end

      // R3 latency: visible in the third cycle
      tx_buf_err[0] = 1'b1;
      @(negedge clk); tx_buf_err[0] = 1'b0;
      @(negedge clk);
      chk("R3 latency second cycle", int'(tx_pcs_rst[0]), 0);
      @(negedge clk);
      chk("R3 latency third cycle", int'(tx_pcs_rst[0]), 1);
      repeat (20) @(negedge clk);

      // R2 user clock lock loss
      usr_lock = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 tx held on lock loss", int'(tx_pcs_rst), 3);
      chk("R2 rx held on lock loss", int'(rx_pcs_rst), 3);
      chk("R2 prbs unaffected", int'(prbs_rst), 0);
      usr_lock = 1'b1;
      @(negedge clk);
      chk("R2 still held one edge after return", int'(tx_pcs_rst), 3);
      repeat (2) @(negedge clk);
      chk("R2 released after return", int'({tx_pcs_rst, rx_pcs_rst}), 0);
      repeat (5) @(negedge clk);

      // R9 suppression during tile reset
      clr_counts();
      refclk_evt = 1'b1;
      for (int c = 0; c < WIN; c++) begin
         @(negedge clk);
         if (c == 0) refclk_evt = 1'b0;
         if (c == 5) begin tx_buf_err[0] = 1'b1; bond_req = 1'b1; end
         if (c == 6) begin tx_buf_err[0] = 1'b0; bond_req = 1'b0; end
         accum();
      end
      chk("R9 tile runs", c_tile, 16);
      chk("R9 tx suppressed", c_tx0, 0);
      chk("R9 bond suppressed", c_cd0 + c_cd1, 0);
      repeat (10) @(negedge clk);

      // R10 timeout and retry, R5 no buffer reset without lock
      chk("R10 flag clear before", int'(bond_tmo), 0);
      cdr_lock = '0;
      clr_counts();
      bond_req = 1'b1;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (c == 0) bond_req = 1'b0;
         accum();
      end
      chk("R10 cdr retried", c_cd0, 16);
      chk("R10 timeout flag", int'(bond_tmo), 1);
      chk("R5 no buffer reset without lock", c_bf0 + c_bf1, 0);
      cdr_lock = 2'b01;
      clr_counts();
      repeat (100) begin @(negedge clk); accum(); end
      chk("R5 one lane locked is not enough", c_bf0 + c_bf1, 0);
      cdr_lock = '1;
      clr_counts();
      repeat (100) begin @(negedge clk); accum(); end
      chk("R5 buffer reset after lock lane0", c_bf0, 8);
      chk("R5 buffer reset after lock lane1", c_bf1, 8);
      chk("R10 flag sticky", int'(bond_tmo), 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule